// File: doc/BRIEF.md
# Chroma Burst and Line-Alternation Sequencer

This block sits in front of a quadrature chroma modulator and decides, on every pixel clock, which U/V pair the modulator receives. After each horizontal sync it waits a programmable number of pixel strobes, then holds a constant burst U/V pair for a programmable number of strobes. The modulator's own subcarrier oscillator turns that constant pair into a burst, so the burst phase is set only by the pair chosen. Outside the burst, incoming pixel U/V values pass straight through.

A mode input selects between two colour systems. In the single-phase system (NTSC-style) the burst pair is fixed at 180 degrees and V is never altered. In the line-alternating system (PAL-style) a line-parity flag toggles on every line strobe and is cleared at the start of each field. On odd lines the burst sits at 135 degrees (45 degrees ahead of the 180-degree reference) and pixel V passes unchanged. On even lines the burst sits at 225 degrees (45 degrees behind) and pixel V is negated.

The sequencer has three states. `ST_IDLE` waits for a line. `ST_WAIT` counts the porch delay. `ST_BURST` counts the burst length. The transitions are as follows:
- LINE_RESTART: a line strobe in any state reloads the delay and enters `ST_WAIT`. It enters `ST_BURST` directly when the delay is 0, and stays in `ST_IDLE` when the delay and the length are both 0.
- WAIT_DONE: `ST_WAIT` moves to `ST_BURST` on its last delay strobe, or to `ST_IDLE` if the length is 0.
- BURST_DONE: `ST_BURST` moves to `ST_IDLE` on its last length strobe.

Top module: `chroma_burst_seq`

## Requirements
- R1: After reset `burst_active` is 0, the line parity is even (0), and `mod_u`/`mod_v` equal `pix_u`/`pix_v`.
- R2: The line parity toggles on each `line_start` and is cleared by `field_start`. A `field_start` in the same cycle as a `line_start` wins. The first line strobe after a field start therefore makes the line odd.
- R3: After a `line_start`, `burst_active` rises once `cfg_burst_delay` cycles with `pix_en` high have been sampled. With a delay of 0 it rises in the cycle right after the line strobe.
- R4: `burst_active` stays high for exactly `cfg_burst_len` cycles in which `pix_en` is high. A length of 0 produces no burst.
- R5: Cycles with `pix_en` low neither advance the delay count nor the burst count.
- R6: A `line_start` during the delay or the burst restarts the sequence from the beginning, with the parity toggled.
- R7: With `pal_mode`=0 the burst pair is U = -BURST_AMP and V = 0 (two's complement, default BURST_AMP=40, so U = 0xD8) on every line.
- R8: With `pal_mode`=1 the burst U is -D. The burst V is +D on odd lines and -D on even lines, where D = floor(BURST_AMP*181/256) (28 by default).
- R9: Outside the burst `mod_v` equals `pix_v` when `pal_mode`=0 or the line is odd. On even lines with `pal_mode`=1 it equals the negated `pix_v`, and -128 maps to +127.
- R10: Outside the burst `mod_u` equals `pix_u` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle strobe at the start of a field; clears line parity |
| line_start | input | 1 | One-cycle strobe at the end of horizontal sync |
| pix_en | input | 1 | Pixel-clock enable; delay and burst counts advance only when high |
| pal_mode | input | 1 | 0: single-phase burst, 1: line-alternating burst and V inversion |
| cfg_burst_delay | input | CW | Pixel strobes from sync end to burst start |
| cfg_burst_len | input | CW | Burst length in pixel strobes |
| pix_u | input | DW | Incoming U sample, two's complement |
| pix_v | input | DW | Incoming V sample, two's complement |
| mod_u | output | DW | U value sent to the modulator |
| mod_v | output | DW | V value sent to the modulator |
| burst_active | output | 1 | High while the burst pair is being driven |

## Verification
The state register and the parity flag both update on the edge that samples a strobe. `burst_active`, `mod_u` and `mod_v` are decoded combinationally from those registers and from the pixel inputs. A line strobe therefore shows its effect one cycle later, and a change on `pix_u`/`pix_v` shows in the same cycle. With `pix_en` held high, the burst rises `cfg_burst_delay` edges after the edge that sampled `line_start`, and lasts `cfg_burst_len` edges. The bench drives every input 1 ns after a rising edge and reads the outputs at that same point. Each strobe is counted against exactly the edges it was presented to, and the bench counts the length of the burst rather than assuming it.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } burst_st_e;
endpackage

// File: rtl/cbs_line_parity.sv
module cbs_line_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic field_start,
    input  logic line_start,
    output logic odd_line
);
    always_ff @(posedge clk) begin
        if (!rst_n)           odd_line <= 1'b0;
        else if (field_start) odd_line <= 1'b0;
        else if (line_start)  odd_line <= ~odd_line;
    end

    assert_field_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !odd_line);
    assert_line_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !field_start) |=> (odd_line != $past(odd_line)));
    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !field_start) |=> $stable(odd_line));
endmodule

// File: rtl/cbs_burst_fsm.sv
module cbs_burst_fsm
    import cbs_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          pix_en,
    input  logic [CW-1:0] cfg_burst_delay,
    input  logic [CW-1:0] cfg_burst_len,
    output logic          burst_on
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    burst_st_e     st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= ZERO;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (line_start) begin
            // LINE_RESTART
            if (cfg_burst_delay != ZERO) begin
                st_n  = ST_WAIT;
                cnt_n = cfg_burst_delay;
            end else if (cfg_burst_len != ZERO) begin
                st_n  = ST_BURST;
                cnt_n = cfg_burst_len;
            end else begin
                st_n  = ST_IDLE;
                cnt_n = ZERO;
            end
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st_n = ST_IDLE;
                end
                ST_WAIT: begin
                    if (pix_en) begin
                        if (cnt <= ONE) begin
                            // WAIT_DONE
                            if (cfg_burst_len != ZERO) begin
                                st_n  = ST_BURST;
                                cnt_n = cfg_burst_len;
                            end else begin
                                st_n  = ST_IDLE;
                                cnt_n = ZERO;
                            end
                        end else begin
                            cnt_n = cnt - ONE;
                        end
                    end
                end
                ST_BURST: begin
                    if (pix_en) begin
                        if (cnt <= ONE) begin
                            // BURST_DONE
                            st_n  = ST_IDLE;
                            cnt_n = ZERO;
                        end else begin
                            cnt_n = cnt - ONE;
                        end
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = ZERO;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        burst_on = (st == ST_BURST);
    end

    assert_zero_delay_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && cfg_burst_delay == ZERO && cfg_burst_len != ZERO) |=> burst_on);
    assert_burst_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_on |-> (cnt != ZERO));
    assert_zero_len_no_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && cfg_burst_len == ZERO) |=> !burst_on);
    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !line_start) |=> ($stable(st) && $stable(cnt)));
endmodule

// File: rtl/cbs_chroma_mux.sv
module cbs_chroma_mux #(
    parameter int DW        = 8,
    parameter int BURST_AMP = 40
) (
    input  logic          pal_mode,
    input  logic          odd_line,
    input  logic          burst_on,
    input  logic [DW-1:0] pix_u,
    input  logic [DW-1:0] pix_v,
    output logic [DW-1:0] mod_u,
    output logic [DW-1:0] mod_v
);
    localparam int            DIAG     = (BURST_AMP * 181) / 256;
    localparam int            NEG_AMP  = -BURST_AMP;
    localparam int            NEG_DIAG = -DIAG;
    localparam logic [DW-1:0] NTSC_U   = NEG_AMP[DW-1:0];
    localparam logic [DW-1:0] PAL_U    = NEG_DIAG[DW-1:0];
    localparam logic [DW-1:0] PAL_VP   = DIAG[DW-1:0];
    localparam logic [DW-1:0] PAL_VN   = NEG_DIAG[DW-1:0];
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic          v_flip;
    logic [DW-1:0] v_neg;

    always_comb begin
        v_flip = pal_mode && !odd_line;
        v_neg  = (pix_v == MOST_NEG) ? MOST_POS : (~pix_v + DW'(1));
        if (burst_on) begin
            if (pal_mode) begin
                mod_u = PAL_U;
                mod_v = odd_line ? PAL_VP : PAL_VN;
            end else begin
                mod_u = NTSC_U;
                mod_v = '0;
            end
        end else begin
            mod_u = pix_u;
            mod_v = v_flip ? v_neg : pix_v;
        end
    end
endmodule

// File: rtl/chroma_burst_seq.sv
module chroma_burst_seq #(
    parameter int DW        = 8,
    parameter int CW        = 8,
    parameter int BURST_AMP = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_start,
    input  logic          line_start,
    input  logic          pix_en,
    input  logic          pal_mode,
    input  logic [CW-1:0] cfg_burst_delay,
    input  logic [CW-1:0] cfg_burst_len,
    input  logic [DW-1:0] pix_u,
    input  logic [DW-1:0] pix_v,
    output logic [DW-1:0] mod_u,
    output logic [DW-1:0] mod_v,
    output logic          burst_active
);
    logic odd_line;
    logic burst_on;

    cbs_line_parity u_parity (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .line_start  (line_start),
        .odd_line    (odd_line)
    );

    cbs_burst_fsm #(.CW(CW)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_start      (line_start),
        .pix_en          (pix_en),
        .cfg_burst_delay (cfg_burst_delay),
        .cfg_burst_len   (cfg_burst_len),
        .burst_on        (burst_on)
    );

    cbs_chroma_mux #(.DW(DW), .BURST_AMP(BURST_AMP)) u_mux (
        .pal_mode (pal_mode),
        .odd_line (odd_line),
        .burst_on (burst_on),
        .pix_u    (pix_u),
        .pix_v    (pix_v),
        .mod_u    (mod_u),
        .mod_v    (mod_v)
    );

    assign burst_active = burst_on;

    assert_u_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> (mod_u == pix_u));
    assert_ntsc_v_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pal_mode && !burst_active) |-> (mod_v == pix_v));
    assert_ntsc_burst_v_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pal_mode && burst_active) |-> (mod_v == '0));
    assert_pal_burst_swing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_mode && burst_active) |-> (mod_v[DW-1] == !odd_line));
endmodule

// File: tb/test_chroma_burst_seq.sv
module test_chroma_burst_seq;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int AMP = 40;
    localparam int DIAG = (AMP * 181) / 256;

    typedef struct packed {
        logic       pal;
        logic [1:0] lines;
        logic [7:0] dly;
        logic [7:0] len;
        logic [7:0] pu;
        logic [7:0] pv;
        logic [7:0] ebu;
        logic [7:0] ebv;
        logic [7:0] epv;
    } vec_t;

    // pal, lines after field start, delay, length, pix_u, pix_v, burst U, burst V, V outside burst
    localparam vec_t VECS [8] = '{
        '{1'b0, 2'd1, 8'd3, 8'd9,  8'h0A, 8'h14, 8'hD8, 8'h00, 8'h14},
        '{1'b0, 2'd2, 8'd0, 8'd5,  8'hFB, 8'hC4, 8'hD8, 8'h00, 8'hC4},
        '{1'b1, 2'd1, 8'd2, 8'd10, 8'h07, 8'h32, 8'hE4, 8'h1C, 8'h32},
        '{1'b1, 2'd2, 8'd4, 8'd6,  8'h07, 8'h32, 8'hE4, 8'hE4, 8'hCE},
        '{1'b1, 2'd2, 8'd1, 8'd3,  8'h00, 8'h80, 8'hE4, 8'hE4, 8'h7F},
        '{1'b1, 2'd1, 8'd0, 8'd1,  8'h01, 8'h80, 8'hE4, 8'h1C, 8'h80},
        '{1'b0, 2'd1, 8'd5, 8'd0,  8'h03, 8'h04, 8'hD8, 8'h00, 8'h04},
        '{1'b1, 2'd2, 8'd8, 8'd12, 8'h55, 8'h9C, 8'hE4, 8'hE4, 8'h64}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          field_start = 1'b0;
    logic          line_start = 1'b0;
    logic          pix_en = 1'b1;
    logic          pal_mode = 1'b0;
    logic [CW-1:0] cfg_burst_delay = '0;
    logic [CW-1:0] cfg_burst_len = '0;
    logic [DW-1:0] pix_u = '0;
    logic [DW-1:0] pix_v = '0;
    logic [DW-1:0] mod_u;
    logic [DW-1:0] mod_v;
    logic          burst_active;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    chroma_burst_seq #(.DW(DW), .CW(CW), .BURST_AMP(AMP)) i_chroma_burst_seq (
        .clk (clk), .rst_n (rst_n), .field_start (field_start), .line_start (line_start),
        .pix_en (pix_en), .pal_mode (pal_mode), .cfg_burst_delay (cfg_burst_delay),
        .cfg_burst_len (cfg_burst_len), .pix_u (pix_u), .pix_v (pix_v),
        .mod_u (mod_u), .mod_v (mod_v), .burst_active (burst_active)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_field();
        field_start = 1'b1; tick(); field_start = 1'b0;
    endtask

    task automatic strobe_line();
        line_start = 1'b1; tick(); line_start = 1'b0;
    endtask

    // counts cycles with burst_active high, pix_en held high
    task automatic measure(output int n);
        n = 0;
        while (burst_active && n < 300) begin
            n = n + 1;
            tick();
        end
    endtask

    initial begin
        int n;
        pix_u = 8'h21; pix_v = 8'hF0;
        repeat (3) tick();
        // R1: reset state, U/V pass through
        check(burst_active == 1'b0, "R1 burst_active in reset", burst_active, 0);
        rst_n = 1'b1;
        tick();
        check(burst_active == 1'b0, "R1 burst_active after reset", burst_active, 0);
        check(mod_u == pix_u && mod_v == pix_v, "R1 passthrough after reset", mod_v, pix_v);
        pal_mode = 1'b1;
        #1;
        check(mod_v == 8'h10, "R1 parity even after reset (V negated)", mod_v, 8'h10);
        pal_mode = 1'b0;

        // table walk: R2 R3 R4 R7 R8 R9 R10
        for (int i = 0; i < 8; i++) begin
            pal_mode = VECS[i].pal;
            cfg_burst_delay = VECS[i].dly;
            cfg_burst_len = VECS[i].len;
            pix_u = VECS[i].pu;
            pix_v = VECS[i].pv;
            pix_en = 1'b1;
            strobe_field();
            for (int k = 0; k < int'(VECS[i].lines); k++) strobe_line();
            if (VECS[i].dly != 0) begin
                check(burst_active == 1'b0, "R3 no burst during delay", burst_active, 0);
                check(mod_u == VECS[i].pu, "R10 U passthrough", mod_u, VECS[i].pu);
                check(mod_v == VECS[i].epv, "R9 V before burst", mod_v, VECS[i].epv);
                repeat (int'(VECS[i].dly) - 1) tick();
                check(burst_active == 1'b0, "R3 no burst one strobe early", burst_active, 0);
                tick();
            end
            if (VECS[i].len != 0) begin
                check(burst_active == 1'b1, "R3 burst starts after delay", burst_active, 1);
                check(mod_u == VECS[i].ebu, VECS[i].pal ? "R8 burst U" : "R7 burst U", mod_u, VECS[i].ebu);
                check(mod_v == VECS[i].ebv, VECS[i].pal ? "R8 burst V" : "R7 burst V", mod_v, VECS[i].ebv);
            end
            measure(n);
            check(n == int'(VECS[i].len), "R4 burst length", n, VECS[i].len);
            check(mod_v == VECS[i].epv, "R9 V after burst", mod_v, VECS[i].epv);
            check(mod_u == VECS[i].pu, "R10 U after burst", mod_u, VECS[i].pu);
        end

        // R5: stalled pixel enable holds both counts
        pal_mode = 1'b0; cfg_burst_delay = 8'd2; cfg_burst_len = 8'd2;
        strobe_line();
        pix_en = 1'b0;
        repeat (5) tick();
        check(burst_active == 1'b0, "R5 delay frozen while pix_en low", burst_active, 0);
        pix_en = 1'b1;
        tick(); tick();
        check(burst_active == 1'b1, "R5 burst after two enabled strobes", burst_active, 1);
        pix_en = 1'b0;
        repeat (3) tick();
        check(burst_active == 1'b1, "R5 burst frozen while pix_en low", burst_active, 1);
        pix_en = 1'b1;
        tick();
        check(burst_active == 1'b1, "R5 burst one strobe left", burst_active, 1);
        tick();
        check(burst_active == 1'b0, "R5 burst ends after two strobes", burst_active, 0);

        // R6: restart in the middle of a burst, with parity toggle seen in PAL burst V
        pal_mode = 1'b1; cfg_burst_delay = 8'd0; cfg_burst_len = 8'd4;
        strobe_field();
        strobe_line();
        check(mod_v == 8'(DIAG), "R6 odd-line burst V before restart", mod_v, DIAG);
        tick(); tick();
        strobe_line();
        check(burst_active == 1'b1 && mod_v == 8'(-DIAG), "R6 restarted burst on even line", mod_v, 8'(-DIAG));
        measure(n);
        check(n == 4, "R6 restarted burst full length", n, 4);

        // R2: field strobe wins over a simultaneous line strobe
        strobe_line();
        measure(n);
        field_start = 1'b1; line_start = 1'b1; tick();
        field_start = 1'b0; line_start = 1'b0;
        check(mod_v == 8'(-DIAG), "R2 field start wins, line even", mod_v, 8'(-DIAG));
        measure(n);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule